// File: doc/BRIEF.md
# Platform Interrupt Controller

This block gathers level-sensitive interrupt lines from up to `NUM_SRC-1` sources and steers them to `NCTX` interrupt targets (contexts), for example one machine-mode and one supervisor-mode context on a single core. Software programs a priority for each source, an enable mask and a priority threshold for each context. Each context has one interrupt output. It is high while at least one enabled, pending and unclaimed source has a priority strictly above that context's threshold.

A handler claims work by reading its context's claim/complete word. The read returns the winning source number, or 0 if there is none. In the same cycle the read moves that source from pending to claimed, so no other context can take it. When the handler is done it writes the source number back to the same word. The source then competes again if its line is still high. All registers sit on a simple word-wide read/write bus. Read data appears one cycle after the read strobe.

Top module: `irqc_top`

## Requirements
- R1: After reset all priorities, thresholds, enables, pending and claimed bits read 0, and every `eip_o` bit is 0.
- R2: The priority of source `s` (1 ≤ s < NUM_SRC) is the word at byte address `4*(s-1)` and reads back what was stored. Slots with no valid source read 0 and ignore writes.
- R3: With `MAX_PRIO+1` a power of two, priority and threshold writes keep `wdata & MAX_PRIO` (default 7: writing 13 reads 5). Otherwise a write above `MAX_PRIO` is dropped and the old value is kept.
- R4: The read-only word at `0x1000` has bit `s` = 1 while the line `irq_i[s]` is high and source `s` is not claimed. Bit 0 is always 0, and writes to this word are ignored.
- R5: The enable word of context `c` is at `0x2000 + c*0x80` and reads back what was written (bit `s` enables source `s`). Words at or beyond `ceil(NUM_SRC/32)` read 0 and ignore writes.
- R6: A context's winner is the enabled, pending, unclaimed source with the highest priority strictly greater than the context threshold. Among equal priorities the lowest source number wins. With no such source the winner is 0.
- R7: Reading `0x20_0004 + c*0x1000` returns context `c`'s winner and marks that source claimed. A claimed source is excluded from every context and shows 0 in the pending word even while its line stays high.
- R8: Writing a value `v < NUM_SRC` to any claim/complete word clears the claimed bit of source `v`. Values `v ≥ NUM_SRC` are ignored and are not truncated. After completion a still-high line makes the source pending again.
- R9: `eip_o[c]` is a register that is 1 exactly when context `c` had a nonzero winner in the previous cycle.
- R10: Accesses with `addr_i[1:0] != 0`, or to unmapped addresses (including offsets other than 0 and 4 in a context block), return 0 on read and change nothing on write.
- R11: `rdata_o` is updated only at a clock edge where `rd_en_i` is high, and holds its value otherwise.
- R12: The threshold of context `c` is at `0x20_0000 + c*0x1000`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe (a claim read has a side effect) |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| irq_i | input | NUM_SRC | Level interrupt lines, bit s = source s (bit 0 unused) |
| eip_o | output | NCTX | Interrupt request per context |

## Verification
Arbitration is tried with three patterns, each of which tells a different fault apart.
- A lone source sits at and above the threshold, which separates a strict comparison from a non-strict one.
- Three sources with distinct priorities are claimed one after another, which shows the claim order and that a claimed source with its line still high is skipped.
- Two sources share the top priority, which shows whether the lowest number wins.

The completion path is driven with an out-of-range number whose low bits alias a claimed source, and then with a valid one. Line drops and a mid-run reset with lines still high show that pending tracks the level. A second instance with a non-power-of-two level count separates dropping an illegal write from wrapping it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // True when every written value can be made legal by masking.
  function automatic logic lvl_wraps(input int unsigned maxp);
    return ((maxp + 1) & maxp) == 0;
  endfunction

  // Whether a priority/threshold write is accepted at all.
  function automatic logic lvl_ok(input logic [31:0] v, input int unsigned maxp);
    if (lvl_wraps(maxp)) return 1'b1;
    return v <= maxp;
  endfunction

  // Value kept by an accepted write.
  function automatic logic [31:0] lvl_fit(input logic [31:0] v, input int unsigned maxp);
    if (lvl_wraps(maxp)) return v & maxp;
    return v;
  endfunction

endpackage

// File: rtl/irqc_srcstate.sv
module irqc_srcstate #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [NUM_SRC-1:0] claim_set_i,
  input  logic [NUM_SRC-1:0] done_clr_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] clm_o
);
  logic [NUM_SRC-1:0] clm_n;

  assign clm_n = (clm_o | claim_set_i) & ~done_clr_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      clm_o  <= '0;
      pend_o <= '0;
    end else begin
      clm_o  <= clm_n;
      // pending tracks the line, but a claimed source is held out
      pend_o <= irq_i & ~clm_n & ~NUM_SRC'(1);
    end
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PW      = 3,
  localparam int IDW    = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]    cand_i,
  input  logic [NUM_SRC*PW-1:0] prio_i,
  input  logic [PW-1:0]         thr_i,
  output logic [IDW-1:0]        win_o
);
  logic [PW-1:0] best;

  // ascending scan with strict compare: lowest ID wins a tie
  always_comb begin
    best  = thr_i;
    win_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand_i[i] && prio_i[i*PW +: PW] > best) begin
        best  = prio_i[i*PW +: PW];
        win_o = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top import irqc_pkg::*; #(
  parameter int          NUM_SRC   = 32,
  parameter int          NCTX      = 2,
  parameter int unsigned MAX_PRIO  = 7,
  parameter int          AW        = 24,
  parameter int unsigned PRIO_BASE = 32'h0000_0000,
  parameter int unsigned PEND_BASE = 32'h0000_1000,
  parameter int unsigned EN_BASE   = 32'h0000_2000,
  parameter int          EN_SH     = 7,
  parameter int unsigned CX_BASE   = 32'h0020_0000,
  parameter int          CX_SH     = 12
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               wr_en_i,
  input  logic [31:0]        wdata_i,
  input  logic               rd_en_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC-1:0] irq_i,
  output logic [NCTX-1:0]    eip_o
);
  localparam int IDW   = $clog2(NUM_SRC);
  localparam int PW    = $clog2(MAX_PRIO + 1);
  localparam int WORDS = (NUM_SRC + 31) / 32;
  localparam int VB    = WORDS * 32;

  logic [PW-1:0]      prio_q [NUM_SRC];
  logic [PW-1:0]      thr_q  [NCTX];
  logic [31:0]        en_q   [NCTX][WORDS];
  logic [NUM_SRC-1:0] pend_q, clm_q, claim_set, done_clr;
  logic [IDW-1:0]     win_id [NCTX];
  logic [31:0]        rd_val;

  // ---------------- address decode ----------------
  logic          aligned, hit_p, hit_q, hit_e, hit_c, is_thr, is_clm;
  logic [AW-1:0] off_p, off_q, off_e, off_c, e_ctx, c_ctx;
  logic [IDW-1:0] p_id;
  logic [AW-3:0]  q_word;
  logic [EN_SH-3:0] e_word;
  logic [CX_SH-1:0] c_reg;

  assign aligned = addr_i[1:0] == 2'b00;
  assign off_p   = addr_i - AW'(PRIO_BASE);
  assign off_q   = addr_i - AW'(PEND_BASE);
  assign off_e   = addr_i - AW'(EN_BASE);
  assign off_c   = addr_i - AW'(CX_BASE);
  assign hit_p   = aligned && addr_i >= AW'(PRIO_BASE) && off_p < AW'(NUM_SRC * 4);
  assign hit_q   = aligned && addr_i >= AW'(PEND_BASE) && off_q < AW'(WORDS * 4);
  assign hit_e   = aligned && addr_i >= AW'(EN_BASE)   && off_e < AW'(NCTX << EN_SH);
  assign hit_c   = aligned && addr_i >= AW'(CX_BASE)   && off_c < AW'(NCTX << CX_SH);
  assign p_id    = off_p[IDW+1:2] + IDW'(1);
  assign q_word  = off_q[AW-1:2];
  assign e_ctx   = off_e >> EN_SH;
  assign e_word  = off_e[EN_SH-1:2];
  assign c_ctx   = off_c >> CX_SH;
  assign c_reg   = off_c[CX_SH-1:0];
  assign is_thr  = c_reg == '0;
  assign is_clm  = c_reg == CX_SH'(4);

  // ---------------- per-source state ----------------
  irqc_srcstate #(.NUM_SRC(NUM_SRC)) u_src (
    .clk_i(clk_i), .rst_i(rst_i), .irq_i(irq_i),
    .claim_set_i(claim_set), .done_clr_i(done_clr),
    .pend_o(pend_q), .clm_o(clm_q)
  );

  // ---------------- arbitration per context ----------------
  logic [NUM_SRC*PW-1:0] prio_flat;
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_pf
    assign prio_flat[s*PW +: PW] = prio_q[s];
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [VB-1:0] en_flat;
    for (genvar w = 0; w < WORDS; w++) begin : g_w
      assign en_flat[w*32 +: 32] = en_q[c][w];
    end
    irqc_arbiter #(.NUM_SRC(NUM_SRC), .PW(PW)) u_arb (
      .cand_i(pend_q & ~clm_q & en_flat[NUM_SRC-1:0]),
      .prio_i(prio_flat), .thr_i(thr_q[c]), .win_o(win_id[c])
    );
    always_ff @(posedge clk_i) begin
      if (rst_i) eip_o[c] <= 1'b0;
      else       eip_o[c] <= win_id[c] != '0;
    end
  end

  // ---------------- read mux, claim and completion ----------------
  logic [VB-1:0] pend_pad;
  assign pend_pad = VB'(pend_q);

  always_comb begin
    rd_val    = '0;
    claim_set = '0;
    done_clr  = '0;
    if (hit_p)
      for (int s = 1; s < NUM_SRC; s++)
        if (p_id == IDW'(s)) rd_val = 32'(prio_q[s]);
    if (hit_q)
      for (int w = 0; w < WORDS; w++)
        if (q_word == (AW-2)'(w)) rd_val = pend_pad[w*32 +: 32];
    if (hit_e)
      for (int c = 0; c < NCTX; c++)
        for (int w = 0; w < WORDS; w++)
          if (e_ctx == AW'(c) && e_word == (EN_SH-2)'(w)) rd_val = en_q[c][w];
    if (hit_c)
      for (int c = 0; c < NCTX; c++)
        if (c_ctx == AW'(c)) begin
          if (is_thr) rd_val = 32'(thr_q[c]);
          if (is_clm) begin
            rd_val = 32'(win_id[c]);
            if (rd_en_i && win_id[c] != '0) claim_set = NUM_SRC'(1) << win_id[c];
          end
        end
    if (wr_en_i && hit_c && is_clm && wdata_i < 32'(NUM_SRC))
      for (int s = 1; s < NUM_SRC; s++)
        if (wdata_i == 32'(s)) done_clr[s] = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_val;
  end

  // ---------------- register writes ----------------
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int s = 0; s < NUM_SRC; s++) prio_q[s] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        thr_q[c] <= '0;
        for (int w = 0; w < WORDS; w++) en_q[c][w] <= '0;
      end
    end else if (wr_en_i) begin
      if (hit_p && lvl_ok(wdata_i, MAX_PRIO))
        for (int s = 1; s < NUM_SRC; s++)
          if (p_id == IDW'(s)) prio_q[s] <= PW'(lvl_fit(wdata_i, MAX_PRIO));
      if (hit_e)
        for (int c = 0; c < NCTX; c++)
          for (int w = 0; w < WORDS; w++)
            if (e_ctx == AW'(c) && e_word == (EN_SH-2)'(w)) en_q[c][w] <= wdata_i;
      if (hit_c && is_thr && lvl_ok(wdata_i, MAX_PRIO))
        for (int c = 0; c < NCTX; c++)
          if (c_ctx == AW'(c)) thr_q[c] <= PW'(lvl_fit(wdata_i, MAX_PRIO));
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NUM_SRC = 32,
  parameter int NCTX    = 2
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               rd_en_i,
  input logic               wr_en_i,
  input logic [31:0]        rdata_o,
  input logic [NCTX-1:0]    eip_o,
  input logic [NUM_SRC-1:0] clm_q
);
  // R1: a reset cycle leaves outputs quiet
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    rst_i |=> (eip_o == '0 && rdata_o == '0));

  // R7: at most one source becomes claimed per cycle
  assert_single_claim_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(clm_q & ~$past(clm_q)) <= 1);

  // R7: a claim only follows a bus read
  assert_claim_by_read_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (clm_q & ~$past(clm_q)) != '0 |-> $past(rd_en_i));

  // R8: a claimed bit only clears after a bus write
  assert_done_by_write_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(clm_q) & ~clm_q) != '0 |-> $past(wr_en_i));

  // R11: read data holds without a read strobe
  assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind irqc_top irqc_chk #(.NUM_SRC(NUM_SRC), .NCTX(NCTX)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
  .rdata_o(rdata_o), .eip_o(eip_o), .clm_q(clm_q)
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [23:0] a0 = '0, a1 = '0;
  logic [31:0] d0 = '0, d1 = '0, q0, q1;
  logic        we0 = 0, re0 = 0, we1 = 0, re1 = 0;
  logic [31:0] irq = '0;
  logic [1:0]  eip0, eip1;

  irqc_top u0 (.clk_i(clk), .rst_i(rst), .addr_i(a0), .wr_en_i(we0), .wdata_i(d0),
               .rd_en_i(re0), .rdata_o(q0), .irq_i(irq), .eip_o(eip0));
  irqc_top #(.MAX_PRIO(5)) u1 (.clk_i(clk), .rst_i(rst), .addr_i(a1), .wr_en_i(we1),
               .wdata_i(d1), .rd_en_i(re1), .rdata_o(q1), .irq_i(32'h0), .eip_o(eip1));

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input bit sel, input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    if (sel) begin a1 = a; d1 = d; we1 = 1; end
    else     begin a0 = a; d0 = d; we0 = 1; end
    @(negedge clk);
    we0 = 0; we1 = 0;
  endtask

  task automatic bus_rd(input bit sel, input logic [23:0] a, output logic [31:0] q);
    @(negedge clk);
    if (sel) begin a1 = a; re1 = 1; end
    else     begin a0 = a; re0 = 1; end
    @(negedge clk);
    re0 = 0; re1 = 0;
    q = sel ? q1 : q0;
  endtask

  typedef struct packed { logic rd; logic [23:0] a; logic [31:0] d; } vec_t;
  localparam int NV = 27;
  localparam vec_t VT [NV] = '{
    '{1'b1, 24'h000000, 32'h0},         // R1 reset priority
    '{1'b0, 24'h000000, 32'h3},         // R2 source 1
    '{1'b1, 24'h000000, 32'h3},         // R2
    '{1'b0, 24'h000004, 32'd13},        // R3 wrap
    '{1'b1, 24'h000004, 32'h5},         // R3
    '{1'b0, 24'h000078, 32'h7},         // R2 source 31
    '{1'b1, 24'h000078, 32'h7},         // R2
    '{1'b0, 24'h00007C, 32'h4},         // R2 no source 32
    '{1'b1, 24'h00007C, 32'h0},         // R2
    '{1'b0, 24'h002000, 32'hFFFF_FFFE}, // R5 ctx0
    '{1'b1, 24'h002000, 32'hFFFF_FFFE}, // R5
    '{1'b0, 24'h002004, 32'h5},         // R5 word beyond
    '{1'b1, 24'h002004, 32'h0},         // R5
    '{1'b0, 24'h002080, 32'hA},         // R5 ctx1
    '{1'b1, 24'h002080, 32'hA},         // R5
    '{1'b0, 24'h200000, 32'h2},         // R12 threshold ctx0
    '{1'b1, 24'h200000, 32'h2},         // R12
    '{1'b0, 24'h201000, 32'h9},         // R3 threshold wrap ctx1
    '{1'b1, 24'h201000, 32'h1},         // R3
    '{1'b0, 24'h001000, 32'hFFFF},      // R4 write ignored
    '{1'b1, 24'h001000, 32'h0},         // R4
    '{1'b1, 24'h003000, 32'h0},         // R10 unmapped
    '{1'b0, 24'h000001, 32'h6},         // R10 misaligned write
    '{1'b1, 24'h000000, 32'h3},         // R10 unchanged
    '{1'b1, 24'h000002, 32'h0},         // R10 misaligned read
    '{1'b1, 24'h200008, 32'h0},         // R10 unused ctx offset
    '{1'b1, 24'h202000, 32'h0}          // R10 no context 2
  };

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    ticks(3);
    rst = 0;
    ticks(1);
    chk("R1 eip after reset", 32'(eip0), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VT[i].rd) begin
        bus_rd(0, VT[i].a, r);
        chk($sformatf("table %0d addr %h", i, VT[i].a), r, VT[i].d);
      end else begin
        bus_wr(0, VT[i].a, VT[i].d);
      end
    end

    // R9 R6: single source above both thresholds
    irq[1] = 1; ticks(3);
    chk("R9 eip both contexts", 32'(eip0), 32'h3);
    bus_rd(0, 24'h001000, r); chk("R4 pending follows line", r, 32'h2);
    // R6 strict threshold
    bus_wr(0, 24'h200000, 32'h3); ticks(2);
    chk("R6 equal to threshold loses", 32'(eip0), 32'h2);
    bus_wr(0, 24'h200000, 32'h0);

    // R7 claims in priority order
    irq[2] = 1; irq[31] = 1; ticks(3);
    bus_rd(0, 24'h200004, r); chk("R7 claim prio 7", r, 32'd31);
    bus_rd(0, 24'h200004, r); chk("R7 claim prio 5", r, 32'd2);
    bus_rd(0, 24'h200004, r); chk("R7 claim prio 3", r, 32'd1);
    bus_rd(0, 24'h200004, r); chk("R6 no winner", r, 32'd0);
    bus_rd(0, 24'h001000, r); chk("R7 claimed not pending", r, 32'h0);
    ticks(2);
    chk("R9 eip low when all claimed", 32'(eip0), 32'h0);
    bus_rd(0, 24'h000000, r); ticks(3);
    chk("R11 rdata held", q0, 32'h3);

    // R8 completion
    bus_wr(0, 24'h200004, 32'd34); ticks(2);
    bus_rd(0, 24'h001000, r); chk("R8 out-of-range complete ignored", r, 32'h0);
    bus_wr(0, 24'h200004, 32'd31); ticks(2);
    bus_rd(0, 24'h001000, r); chk("R8 completed source pending again", r, 32'h8000_0000);
    chk("R9 eip ctx0 only", 32'(eip0), 32'h1);

    // R6 tie goes to lowest ID
    bus_wr(0, 24'h000004, 32'h7);
    bus_wr(0, 24'h200004, 32'd2); ticks(2);
    bus_rd(0, 24'h200004, r); chk("R6 tie lowest ID", r, 32'd2);

    // R7 claim via context 1
    bus_wr(0, 24'h200004, 32'd1); ticks(2);
    bus_rd(0, 24'h201004, r); chk("R7 ctx1 claim", r, 32'd1);

    // R4 line drop clears pending
    irq[31] = 0; ticks(3);
    bus_rd(0, 24'h001000, r); chk("R4 line low clears pending", r, 32'h0);
    chk("R9 eip low", 32'(eip0), 32'h0);

    // R3 drop mode on second instance
    bus_wr(1, 24'h000000, 32'h4);
    bus_wr(1, 24'h000000, 32'h6);
    bus_rd(1, 24'h000000, r); chk("R3 drop above max", r, 32'h4);
    bus_wr(1, 24'h000000, 32'h5);
    bus_rd(1, 24'h000000, r); chk("R3 max accepted", r, 32'h5);
    bus_wr(1, 24'h200000, 32'h7);
    bus_rd(1, 24'h200000, r); chk("R3 threshold drop", r, 32'h0);

    // R1 reset in the middle of traffic
    @(negedge clk); rst = 1; ticks(2); rst = 0; ticks(1);
    chk("R1 eip cleared", 32'(eip0), 32'h0);
    bus_rd(0, 24'h000078, r); chk("R1 priority cleared", r, 32'h0);
    bus_rd(0, 24'h002000, r); chk("R1 enable cleared", r, 32'h0);
    bus_rd(0, 24'h200004, r); chk("R1 claim none", r, 32'h0);
    bus_rd(0, 24'h001000, r); chk("R1 R4 pending from lines", r, 32'h6);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule